// File: doc/BRIEF.md
# Power-State Indicator Control Register

This block is a 16-bit control register that a power-management unit uses to drive a two-pin multi-colour indicator LED. Each of the two indicator pins has its own two-bit mode: held low, held high or blinking at about 1 Hz. A single ownership bit decides whether the two shared package pins carry the indicator outputs or pass through two general-purpose I/O signals. The register also holds a resume-event routing option (SMI or SCI) and a power-button intercept enable, which takes effect only while the system is in the S0 working state.

Two bits of the register are write-only commands. Writing 1 to either bit produces a single-cycle pulse that sets a status flag held elsewhere (the "SCI now" flag and the power-button flag). The command bits store nothing and read back as 0. Writes are qualified by two byte enables, so that either byte can be written on its own. The blink timing comes from one shared divider whose phase is a two-state machine (`PH_DARK`, `PH_LIT`). It steps `PH_DARK -> PH_LIT` and `PH_LIT -> PH_DARK` on each terminal count of a half-period counter, and reset puts it in `PH_DARK`.

Field layout (bit positions as seen on `wr_data` and `rd_data`): bit 0 resume-event SMI select, bit 1 SCI-now command, bit 2 power-button intercept enable, bit 3 power-button event command, bits 5:4 mode of pin 0, bits 7:6 mode of pin 1, bit 8 indicator ownership, bits 15:9 reserved. Byte enable 0 covers bits 7:0 and byte enable 1 covers bits 15:8.

Top module: `pwr_led_ctrl`

## Requirements
- R1: While reset is asserted and after reset, `rd_data` reads 0000h, both command pulses are low, `smi_select` and `intercept_active` are low, and `pin_out` equals `gpio_in` (ownership clear).
- R2: A write with `wr_be[0]`=0 leaves bits 7:0 unchanged, and a write with `wr_be[1]`=0 leaves bits 15:8 unchanged. An enabled byte takes the written value in the cycle after the write edge.
- R3: Reserved bits 15:9 and command bits 1 and 3 always read 0, whatever is written.
- R4: With ownership bit 8 at 0, `pin_out[i]` equals `gpio_in[i]` for any mode value.
- R5: With ownership at 1, mode 2'b00 drives the pin low, 2'b01 drives it high and the reserved value 2'b11 drives it low.
- R6: With ownership at 1, mode 2'b10 makes the pin follow the shared blink phase. The phase is low for the first HALF clock edges after reset release and then toggles every HALF edges, where HALF = CLK_HZ/(2*BLINK_HZ). Both pins blink in phase.
- R7: A write with `wr_be[0]`=1 and `wr_data[1]`=1 makes `sci_now_pulse` high for exactly the one cycle after the write edge. Otherwise the pulse stays low.
- R8: A write with `wr_be[0]`=1 and `wr_data[3]`=1 makes `pwrbtn_evt_pulse` high for exactly the one cycle after the write edge. Otherwise the pulse stays low.
- R9: `intercept_active` is high exactly when the stored intercept enable (bit 2) is 1 and `in_s0` is 1.
- R10: `smi_select` equals the stored bit 0 (1 routes resume events to SMI, 0 to SCI).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_be | input | 2 | Byte enables: [0] bits 7:0, [1] bits 15:8 |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register read value |
| in_s0 | input | 1 | High while the system is in the S0 working state |
| gpio_in | input | 2 | General-purpose signals shared with the indicator pins |
| pin_out | output | 2 | Shared package pins |
| smi_select | output | 1 | Resume-event routing: 1 SMI, 0 SCI |
| intercept_active | output | 1 | Power-button intercept in effect |
| sci_now_pulse | output | 1 | One-cycle pulse that sets the SCI-now status |
| pwrbtn_evt_pulse | output | 1 | One-cycle pulse that sets the power-button status |

## Verification
The bench writes the high byte alone to catch a design that ties both bytes to one enable, which would clobber the modes or the routing bit. It writes all ones to catch reserved or command bits that get stored and read back. It sets the reserved mode 11 to expose an undefined or blinking pin. It follows the blink phase edge by edge from reset release to expose a divider that is off by one or starts in the lit phase. Back-to-back writes and writes with the command bits clear expose pulses that stretch, stick or fire without cause. Random writes with random GPIO and S0 inputs check that ownership fully gates the modes, and that the intercept enable is masked outside S0.

// File: rtl/pwr_led_pkg.sv
package pwr_led_pkg;

    localparam int unsigned N_PINS  = 2;
    localparam int unsigned REG_W   = 16;

    // Bit positions of the register fields
    localparam int unsigned B_SMI   = 0;
    localparam int unsigned B_SCI   = 1;
    localparam int unsigned B_ICPT  = 2;
    localparam int unsigned B_PBEV  = 3;
    localparam int unsigned B_MODE  = 4;
    localparam int unsigned B_OWN   = 8;

    typedef enum logic [1:0] {
        LED_LOW   = 2'b00,
        LED_HIGH  = 2'b01,
        LED_BLINK = 2'b10,
        LED_RSVD  = 2'b11
    } led_mode_e;

    typedef enum logic {
        PH_DARK = 1'b0,
        PH_LIT  = 1'b1
    } blink_ph_e;

endpackage

// File: rtl/pwr_led_regs.sv
module pwr_led_regs
    import pwr_led_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_be,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic [2*N_PINS-1:0] modes,
    output logic                own,
    output logic                smi_sel,
    output logic                icpt_en,
    output logic                sci_pulse,
    output logic                pbev_pulse
);

    logic lo_wr;
    logic hi_wr;

    assign lo_wr = wr_en && wr_be[0];
    assign hi_wr = wr_en && wr_be[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smi_sel <= 1'b0;
            icpt_en <= 1'b0;
            modes   <= '0;
        end else if (lo_wr) begin
            smi_sel <= wr_data[B_SMI];
            icpt_en <= wr_data[B_ICPT];
            modes   <= wr_data[B_MODE +: 2*N_PINS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own <= 1'b0;
        end else if (hi_wr) begin
            own <= wr_data[B_OWN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sci_pulse  <= 1'b0;
            pbev_pulse <= 1'b0;
        end else begin
            sci_pulse  <= lo_wr && wr_data[B_SCI];
            pbev_pulse <= lo_wr && wr_data[B_PBEV];
        end
    end

    always_comb begin
        rd_data                        = '0;
        rd_data[B_SMI]                 = smi_sel;
        rd_data[B_ICPT]                = icpt_en;
        rd_data[B_MODE +: 2*N_PINS]    = modes;
        rd_data[B_OWN]                 = own;
    end

endmodule

// File: rtl/pwr_led_blink.sv
module pwr_led_blink
    import pwr_led_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 32_768_000,
    parameter int unsigned BLINK_HZ = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);

    localparam int unsigned HALF  = CLK_HZ / (2 * BLINK_HZ);
    localparam int unsigned CNT_W = $clog2(HALF + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic             term;
    blink_ph_e        state;
    blink_ph_e        state_nx;

    assign term = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_DARK: if (term) state_nx = PH_LIT;
            PH_LIT:  if (term) state_nx = PH_DARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_DARK;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            PH_DARK: phase = 1'b0;
            PH_LIT:  phase = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwr_led_pinmux.sv
module pwr_led_pinmux
    import pwr_led_pkg::*;
(
    input  logic [2*N_PINS-1:0] modes,
    input  logic                own,
    input  logic                phase,
    input  logic [N_PINS-1:0]   gpio_in,
    output logic [N_PINS-1:0]   pin_out
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        led_mode_e mode;
        logic      led;

        assign mode = led_mode_e'(modes[2*i +: 2]);

        always_comb begin
            unique case (mode)
                LED_LOW:   led = 1'b0;
                LED_HIGH:  led = 1'b1;
                LED_BLINK: led = phase;
                LED_RSVD:  led = 1'b0;
            endcase
        end

        assign pin_out[i] = own ? led : gpio_in[i];
    end

endmodule

// File: rtl/pwr_led_ctrl.sv
module pwr_led_ctrl
    import pwr_led_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 32_768_000,
    parameter int unsigned BLINK_HZ = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        in_s0,
    input  logic [1:0]  gpio_in,
    output logic [1:0]  pin_out,
    output logic        smi_select,
    output logic        intercept_active,
    output logic        sci_now_pulse,
    output logic        pwrbtn_evt_pulse
);

    logic [2*N_PINS-1:0] modes;
    logic                own;
    logic                icpt_en;
    logic                phase;

    pwr_led_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_be      (wr_be),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .modes      (modes),
        .own        (own),
        .smi_sel    (smi_select),
        .icpt_en    (icpt_en),
        .sci_pulse  (sci_now_pulse),
        .pbev_pulse (pwrbtn_evt_pulse)
    );

    pwr_led_blink #(
        .CLK_HZ   (CLK_HZ),
        .BLINK_HZ (BLINK_HZ)
    ) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    pwr_led_pinmux u_mux (
        .modes   (modes),
        .own     (own),
        .phase   (phase),
        .gpio_in (gpio_in),
        .pin_out (pin_out)
    );

    assign intercept_active = icpt_en && in_s0;

endmodule

// File: rtl/pwr_led_chk.sv
module pwr_led_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic [1:0]  gpio_in,
    input logic [1:0]  pin_out,
    input logic        sci_now_pulse,
    input logic        pwrbtn_evt_pulse
);

    // R2
    lo_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[0]) |=> $stable(rd_data[7:0]));

    // R2
    hi_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[1]) |=> $stable(rd_data[15:8]));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15:9] == 7'd0) && !rd_data[1] && !rd_data[3]);

    // R4
    gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[8] |-> (pin_out == gpio_in));

    // R5
    pin0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[8] && rd_data[5:4] == 2'b01) |-> pin_out[0]);

    // R6
    in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[8] && rd_data[5:4] == 2'b10 && rd_data[7:6] == 2'b10)
            |-> (pin_out[0] == pin_out[1]));

    // R7
    sci_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0] && wr_data[1]) |=> sci_now_pulse);

    // R7
    sci_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_now_pulse |-> $past(wr_en && wr_be[0] && wr_data[1]));

    // R8
    pbev_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0] && wr_data[3]) |=> pwrbtn_evt_pulse);

    // R8
    pbev_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwrbtn_evt_pulse |-> $past(wr_en && wr_be[0] && wr_data[3]));

endmodule

bind pwr_led_ctrl pwr_led_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_be            (wr_be),
    .wr_data          (wr_data),
    .rd_data          (rd_data),
    .gpio_in          (gpio_in),
    .pin_out          (pin_out),
    .sci_now_pulse    (sci_now_pulse),
    .pwrbtn_evt_pulse (pwrbtn_evt_pulse)
);

// File: tb/tb_pwr_led_ctrl.sv
module tb_pwr_led_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 20;
    localparam int BLINK_HZ   = 1;
    localparam int HALF       = CLK_HZ / (2 * BLINK_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        in_s0 = 1'b0;
    logic [1:0]  gpio_in = 2'b00;
    logic [1:0]  pin_out;
    logic        smi_select;
    logic        intercept_active;
    logic        sci_now_pulse;
    logic        pwrbtn_evt_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int ec = 0;

    // Shadow of the stored fields
    bit       m_smi = 0;
    bit       m_icpt = 0;
    bit [1:0] m_m0 = 0;
    bit [1:0] m_m1 = 0;
    bit       m_own = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_led_ctrl #(.CLK_HZ(CLK_HZ), .BLINK_HZ(BLINK_HZ)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_be            (wr_be),
        .wr_data          (wr_data),
        .rd_data          (rd_data),
        .in_s0            (in_s0),
        .gpio_in          (gpio_in),
        .pin_out          (pin_out),
        .smi_select       (smi_select),
        .intercept_active (intercept_active),
        .sci_now_pulse    (sci_now_pulse),
        .pwrbtn_evt_pulse (pwrbtn_evt_pulse)
    );

    // Clock edges since reset release (R6 timing)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ec <= 0;
        else        ec <= ec + 1;
    end

    function automatic bit exp_phase(input int edges);
        return ((edges / HALF) % 2) == 1;
    endfunction

    function automatic bit exp_pin(input bit own, input bit [1:0] mode,
                                   input bit gpio, input bit ph);
        if (!own) return gpio;
        case (mode)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return ph;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] exp_rd();
        return {7'd0, m_own, m_m1, m_m0, 1'b0, m_icpt, 1'b0, m_smi};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        logic [1:0] ep;
        bit ph;
        ph = exp_phase(ec);
        ep[0] = exp_pin(m_own, m_m0, gpio_in[0], ph);
        ep[1] = exp_pin(m_own, m_m1, gpio_in[1], ph);
        chk(rd_data == exp_rd(), {tag, " R2 R3 readback"}, rd_data, exp_rd());
        chk(pin_out == ep, {tag, " R4 R5 R6 pins"}, {14'd0, pin_out}, {14'd0, ep});
        chk(smi_select == m_smi, {tag, " R10 smi_select"},
            {15'd0, smi_select}, {15'd0, m_smi});
        chk(intercept_active == (m_icpt && in_s0), {tag, " R9 intercept"},
            {15'd0, intercept_active}, {15'd0, m_icpt && in_s0});
    endtask

    // Write, check the pulses in the cycle after the edge, then check them low
    task automatic do_write(input logic [1:0] be, input logic [15:0] d);
        bit es, ep;
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        es = be[0] && d[1];
        ep = be[0] && d[3];
        if (be[0]) begin
            m_smi = d[0]; m_icpt = d[2]; m_m0 = d[5:4]; m_m1 = d[7:6];
        end
        if (be[1]) m_own = d[8];
        chk(sci_now_pulse == es, "R7 sci pulse after write",
            {15'd0, sci_now_pulse}, {15'd0, es});
        chk(pwrbtn_evt_pulse == ep, "R8 pwrbtn pulse after write",
            {15'd0, pwrbtn_evt_pulse}, {15'd0, ep});
        check_state("post-write");
        @(negedge clk);
        chk(!sci_now_pulse, "R7 sci pulse one cycle", {15'd0, sci_now_pulse}, 16'h0);
        chk(!pwrbtn_evt_pulse, "R8 pwrbtn pulse one cycle",
            {15'd0, pwrbtn_evt_pulse}, 16'h0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        gpio_in = 2'b10;
        repeat (3) @(negedge clk);
        // R1: values under reset
        chk(rd_data == 16'h0000, "R1 reset readback", rd_data, 16'h0000);
        chk(pin_out == gpio_in, "R1 reset pins follow gpio",
            {14'd0, pin_out}, {14'd0, gpio_in});
        chk(!sci_now_pulse && !pwrbtn_evt_pulse, "R1 reset pulses",
            {14'd0, sci_now_pulse, pwrbtn_evt_pulse}, 16'h0);
        chk(!smi_select && !intercept_active, "R1 reset routing",
            {14'd0, smi_select, intercept_active}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after release");

        // R4: modes high but ownership clear
        do_write(2'b01, 16'h0050);
        for (int g = 0; g < 4; g++) begin
            gpio_in = 2'(g);
            #1;
            check_state("R4 gpio pass");
        end

        // R2: high byte alone, low byte must survive
        do_write(2'b10, 16'hFFFF);
        // R5: high / high
        check_state("R5 high");
        // R5: reserved 11 on both pins -> low
        do_write(2'b01, 16'h00F0);
        check_state("R5 reserved");
        // R2: low byte alone with zeros in the high byte
        do_write(2'b01, 16'h0010);
        check_state("R2 low byte alone");
        // R5: low on pin 0, high on pin 1
        do_write(2'b01, 16'h0040);

        // R3: all ones written to both bytes
        do_write(2'b11, 16'hFFFF);
        chk(rd_data[15:9] == 7'd0 && !rd_data[1] && !rd_data[3], "R3 reserved zero",
            rd_data, exp_rd());

        // R6: both pins blinking, track the phase for several half periods
        do_write(2'b11, 16'h01A0);
        for (int k = 0; k < 4 * HALF; k++) begin
            @(negedge clk);
            check_state("R6 blink");
            chk(pin_out[0] == pin_out[1], "R6 in phase",
                {14'd0, pin_out}, {14'd0, pin_out[0], pin_out[0]});
        end

        // R7 R8: back-to-back command writes
        do_write(2'b01, 16'h00AA);
        do_write(2'b01, 16'h00A8);
        do_write(2'b10, 16'h000A);

        // R9: intercept enable masked outside S0
        do_write(2'b01, 16'h0004);
        in_s0 = 1'b0; #1; check_state("R9 not S0");
        in_s0 = 1'b1; #1; check_state("R9 in S0");
        // R10: SMI routing
        do_write(2'b01, 16'h0001);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            gpio_in = 2'($urandom);
            in_s0   = 1'($urandom);
            do_write(2'($urandom), 16'($urandom));
            repeat ($urandom_range(0, 3)) @(negedge clk);
            check_state("random");
        end

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        m_smi = 0; m_icpt = 0; m_m0 = 0; m_m1 = 0; m_own = 0;
        @(negedge clk);
        chk(rd_data == 16'h0000, "R1 re-reset readback", rd_data, 16'h0000);
        rst_n = 1'b1;
        do_write(2'b11, 16'h0120);
        for (int k = 0; k < 2 * HALF; k++) begin
            @(negedge clk);
            check_state("R6 phase after reset");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule